// File: doc/BRIEF.md
# Mirrored Two-Bank Microcode Store

This block holds microcode in two banks that always carry the same contents. Each read of a bank takes two machine cycles. Fetches are steered to the banks in turn, so one microword per cycle comes out even though neither bank could sustain that rate alone. Besides the main store, each bank has a small dispatch table indexed by the macro-opcode. That table supplies the first microword of every macroinstruction.

Every stored word carries an even-parity bit. A word whose parity fails on its first read is not delivered. The pipeline freezes, and the same location is read again from the other bank, which replaces the bad word. If the second read also fails, a sticky fatal flag is raised. Each bank counts its parity failures. Once a bank's count goes past a threshold, the block switches that bank over to its spare copy. The switch applies to the main store and the dispatch table of that bank together. Microcode is loaded through a write port that updates both banks at once.

Top module: `ucode_mirror_store`

## Requirements
- R1: While reset is held and on its release, out_valid, fatal_err and spare_sel are all 0 and fetch_rdy is 1.
- R2: A fetch accepted at a clock edge (fetch_req high while fetch_rdy is high) presents its word, with out_valid high, after the second following edge. Back-to-back fetches give one word per cycle, in order.
- R3: Accepted fetches alternate between the banks, and the first one after reset uses bank 0. out_bank reports the bank that supplied each delivered word (0 or 1).
- R4: With fetch_entry=1, fetch_op indexes the dispatch table instead of fetch_addr indexing the main store. A write with wr_entry=1 fills the dispatch table at wr_addr[OPW-1:0].
- R5: A write lands in both banks at the same address, so the two banks return identical words for the same location.
- R6: When the word read from the first bank has bad parity, fetch_rdy is low for two cycles. The word then appears two cycles later than R2 states, from the other bank, with the correct value. This holds for main-store and dispatch-table reads alike.
- R7: When both banks return bad parity for a fetch, the word is dropped (no out_valid for it) and fatal_err rises and stays high until reset.
- R8: spare_sel[b] rises on the (THRESH+1)-th parity failure seen from bank b, and stays high until reset. The default THRESH is 2.
- R9: bank_fault[b] (a fault model that inverts data bit 0 of words read from bank b's primary copy) stops corrupting reads from bank b once spare_sel[b] is high, for main-store and dispatch-table reads.
- R10: fetch_req while fetch_rdy is low is ignored: no word is ever delivered for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Request a microword this cycle |
| fetch_entry | input | 1 | 1: read dispatch table by opcode; 0: main store by address |
| fetch_addr | input | AW | Main-store address |
| fetch_op | input | OPW | Macro-opcode indexing the dispatch table |
| fetch_rdy | output | 1 | Fetch accepted this cycle when high |
| wr_en | input | 1 | Write both banks |
| wr_entry | input | 1 | Write targets the dispatch table |
| wr_addr | input | AW | Write address (low OPW bits for the dispatch table) |
| wr_data | input | DW | Microword to store |
| bank_fault | input | 2 | Per-bank fault model on the primary copy |
| out_valid | output | 1 | out_word holds a delivered microword |
| out_word | output | DW | Delivered microword |
| out_bank | output | 1 | Bank that supplied out_word |
| fatal_err | output | 1 | Both banks failed for one fetch (sticky) |
| spare_sel | output | 2 | Per-bank spare copy in use (sticky) |

## Verification
The bench aims at the recovery path. It faults one bank and checks that the retried word comes back two cycles late, from the other bank, with the right value. A design that re-read the same bank would return corrupted data or never deliver the word. It counts failures against the threshold and checks that spare selection rises on exactly the third failure and then also clears dispatch-table reads. An off-by-one counter, or a dispatch table with its own spare control, would show up there. It pushes requests into the stall window, where a design that accepted them would deliver extra words. It also faults both banks together, where a design that forgot to drop the word or to latch the fatal flag would be caught.

// File: rtl/ucode_mirror_store.sv
module ucode_mirror_store #(
  parameter int DW     = 16,
  parameter int AW     = 6,
  parameter int OPW    = 4,
  parameter int THRESH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_req,
  input  logic          fetch_entry,
  input  logic [AW-1:0] fetch_addr,
  input  logic [OPW-1:0] fetch_op,
  output logic          fetch_rdy,
  input  logic          wr_en,
  input  logic          wr_entry,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    bank_fault,
  output logic          out_valid,
  output logic [DW-1:0] out_word,
  output logic          out_bank,
  output logic          fatal_err,
  output logic [1:0]    spare_sel
);
  localparam int MD = 1 << AW;
  localparam int ED = 1 << OPW;
  localparam int CW = $clog2(THRESH + 2);
  localparam logic [CW-1:0] CMAX = CW'(THRESH + 1);
  localparam logic [CW-1:0] CTRIP = CW'(THRESH);

  logic [DW:0] mem_m [2][MD];
  logic [DW:0] mem_e [2][ED];

  logic          v1, e1, b1, v2, e2, b2, w2, rt2, nb;
  logic [AW-1:0] a1, a2;
  logic [CW-1:0] cnt [2];
  logic [DW:0]   raw, rd;
  logic          flt, perr, busy;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < 2; b++) begin
        if (wr_entry) mem_e[b][wr_addr[OPW-1:0]] <= {^wr_data, wr_data};
        else          mem_m[b][wr_addr]          <= {^wr_data, wr_data};
      end
    end
  end

  assign raw  = e2 ? mem_e[b2][a2[OPW-1:0]] : mem_m[b2][a2];
  assign flt  = bank_fault[b2] & ~spare_sel[b2];
  assign rd   = raw ^ {{DW{1'b0}}, flt};
  assign perr = v2 & ~w2 & (^rd);
  assign busy = w2 | perr;
  assign fetch_rdy = ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; e1 <= 1'b0; b1 <= 1'b0; a1 <= '0;
      v2 <= 1'b0; e2 <= 1'b0; b2 <= 1'b0; a2 <= '0;
      w2 <= 1'b0; rt2 <= 1'b0; nb <= 1'b0;
      out_valid <= 1'b0; out_word <= '0; out_bank <= 1'b0;
      fatal_err <= 1'b0; spare_sel <= 2'b00;
      cnt[0] <= '0; cnt[1] <= '0;
    end else begin
      if (perr) begin
        if (cnt[b2] != CMAX) cnt[b2] <= cnt[b2] + 1'b1;
        if (cnt[b2] == CTRIP) spare_sel[b2] <= 1'b1;
      end
      if (busy) begin
        out_valid <= 1'b0;
        if (w2) begin
          w2 <= 1'b0;
        end else if (rt2) begin
          fatal_err <= 1'b1;
          v2 <= 1'b0;
          rt2 <= 1'b0;
        end else begin
          b2 <= ~b2;
          rt2 <= 1'b1;
          w2 <= 1'b1;
        end
      end else begin
        out_valid <= v2;
        out_word <= rd[DW-1:0];
        out_bank <= b2;
        v2 <= v1; e2 <= e1; b2 <= b1; a2 <= a1;
        rt2 <= 1'b0;
        v1 <= fetch_req;
        if (fetch_req) begin
          e1 <= fetch_entry;
          a1 <= fetch_entry ? AW'(fetch_op) : fetch_addr;
          b1 <= nb;
          nb <= ~nb;
        end
      end
    end
  end

  p_bank_alternate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && v2 && !rt2) |-> (b1 != b2));

  p_retry_other_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (perr && !rt2) |=> (w2 && rt2 && (b2 != $past(b2))));

  p_fatal_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_err |=> fatal_err);

  p_spare_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((spare_sel & $past(spare_sel)) == $past(spare_sel)));

  p_hold_when_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((v1 == $past(v1)) && (a1 == $past(a1)) && (b1 == $past(b1))));

endmodule

// File: tb/ucode_mirror_store_tb.sv
`timescale 1ns/1ps
module ucode_mirror_store_tb;
  localparam int DW = 16, AW = 6, OPW = 4;

  logic clk = 0, rst_n = 0;
  logic fetch_req = 0, fetch_entry = 0, fetch_rdy;
  logic [AW-1:0] fetch_addr = '0;
  logic [OPW-1:0] fetch_op = '0;
  logic wr_en = 0, wr_entry = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0] bank_fault = 2'b00;
  logic out_valid, out_bank, fatal_err;
  logic [DW-1:0] out_word;
  logic [1:0] spare_sel;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  ucode_mirror_store u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_entry(fetch_entry),
    .fetch_addr(fetch_addr), .fetch_op(fetch_op), .fetch_rdy(fetch_rdy),
    .wr_en(wr_en), .wr_entry(wr_entry), .wr_addr(wr_addr), .wr_data(wr_data),
    .bank_fault(bank_fault), .out_valid(out_valid), .out_word(out_word),
    .out_bank(out_bank), .fatal_err(fatal_err), .spare_sel(spare_sel));

  // bit 6: dispatch table, bits 5..0: address / opcode
  localparam int NV = 10;
  localparam logic [6:0] VEC [NV] = '{7'h05, 7'h05, 7'h43, 7'h43, 7'h3F,
                                      7'h00, 7'h4F, 7'h00, 7'h40, 7'h2A};

  function automatic logic [15:0] mword(int a);
    return 16'(32'hA000 ^ (a * 305));
  endfunction
  function automatic logic [15:0] eword(int o);
    return 16'(32'h5C3C ^ (o * 1799));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; fetch_req = 0; wr_en = 0;
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && fatal_err == 0, "R1 valid/fatal in reset", {out_valid, fatal_err}, 0);
    chk(spare_sel == 0 && fetch_rdy == 1, "R1 spare/rdy in reset", {spare_sel, fetch_rdy}, 1);
    rst_n = 1;
  endtask

  task automatic wr(input bit ent, input int addr, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_entry = ent; wr_addr = AW'(addr); wr_data = d;
  endtask

  task automatic fetch1(input bit ent, input int addr, output int lat,
                        output logic [15:0] d, output logic bk, output logic rdy2);
    @(negedge clk);
    fetch_req = 1; fetch_entry = ent; fetch_addr = AW'(addr); fetch_op = OPW'(addr);
    lat = 0; d = '0; bk = 0; rdy2 = 1;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (k == 1) fetch_req = 0;
      if (k == 2) rdy2 = fetch_rdy;
      if (out_valid && lat == 0) begin lat = k; d = out_word; bk = out_bank; end
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat, nval;
    logic [15:0] d, got;
    logic bk, r2;

    do_reset();
    @(negedge clk);
    chk(out_valid == 0 && fetch_rdy == 1 && fatal_err == 0, "R1 after release", {out_valid, fetch_rdy, fatal_err}, 3'b010);

    for (int a = 0; a < (1 << AW); a++) wr(0, a, mword(a));
    for (int o = 0; o < (1 << OPW); o++) wr(1, o, eword(o));
    @(negedge clk); wr_en = 0;

    // table walk: back-to-back fetches, one word per cycle
    do_reset();
    for (int i = 0; i < NV + 3; i++) begin
      @(negedge clk);
      if (i >= 3) begin
        logic [15:0] exp;
        exp = VEC[i-3][6] ? eword(int'(VEC[i-3][3:0])) : mword(int'(VEC[i-3][5:0]));
        chk(out_valid == 1, "R2 word every cycle", out_valid, 1);
        chk(out_word == exp, "R4/R5 word value", out_word, exp);
        chk(out_bank == 1'((i-3) % 2), "R3 bank alternation", out_bank, (i-3) % 2);
      end
      if (i < NV) begin
        fetch_req = 1; fetch_entry = VEC[i][6];
        fetch_addr = VEC[i][5:0]; fetch_op = VEC[i][3:0];
      end else fetch_req = 0;
    end
    @(negedge clk);
    chk(out_valid == 0, "R2 stream ends", out_valid, 0);

    // single-bank faults, threshold and spare switch
    do_reset();
    bank_fault = 2'b01;
    fetch1(0, 7, lat, d, bk, r2);
    chk(lat == 5, "R6 retry latency", lat, 5);
    chk(d == mword(7), "R6 retried data", d, mword(7));
    chk(bk == 1, "R6 retry from other bank", bk, 1);
    chk(r2 == 0, "R6 rdy low in recovery", r2, 0);
    chk(spare_sel == 2'b00, "R8 below threshold (1)", spare_sel, 0);
    fetch1(0, 8, lat, d, bk, r2);
    chk(lat == 3 && d == mword(8), "R2 healthy bank", lat, 3);
    fetch1(0, 9, lat, d, bk, r2);
    chk(lat == 5 && d == mword(9), "R6 second error", lat, 5);
    chk(spare_sel == 2'b00, "R8 below threshold (2)", spare_sel, 0);
    fetch1(0, 10, lat, d, bk, r2);
    fetch1(1, 2, lat, d, bk, r2);
    chk(lat == 5 && d == eword(2), "R6 dispatch retry", d, eword(2));
    chk(spare_sel == 2'b01, "R8 spare at third error", spare_sel, 1);
    fetch1(0, 11, lat, d, bk, r2);
    fetch1(0, 12, lat, d, bk, r2);
    chk(lat == 3 && bk == 0 && d == mword(12), "R9 spare clears main read", lat, 3);
    fetch1(0, 13, lat, d, bk, r2);
    fetch1(1, 9, lat, d, bk, r2);
    chk(lat == 3 && bk == 0 && d == eword(9), "R9 dispatch follows spare", lat, 3);
    chk(spare_sel == 2'b01, "R8 spare sticky", spare_sel, 1);

    // requests during the stall are ignored
    do_reset();
    bank_fault = 2'b01;
    @(negedge clk); fetch_req = 1; fetch_entry = 0; fetch_addr = AW'(20);
    @(negedge clk); fetch_req = 0;
    nval = 0; got = '0;
    @(negedge clk);
    chk(fetch_rdy == 0, "R6 rdy low at stall", fetch_rdy, 0);
    fetch_req = 1; fetch_addr = AW'(21);
    @(negedge clk);
    chk(fetch_rdy == 0, "R10 still stalled", fetch_rdy, 0);
    @(negedge clk); fetch_req = 0;
    for (int k = 0; k < 10; k++) begin
      if (out_valid) begin nval++; got = out_word; end
      @(negedge clk);
    end
    chk(nval == 1, "R10 stalled request dropped", nval, 1);
    chk(got == mword(20), "R10 only first word", got, mword(20));

    // both banks bad
    do_reset();
    bank_fault = 2'b11;
    fetch1(0, 30, lat, d, bk, r2);
    chk(lat == 0, "R7 word dropped", lat, 0);
    chk(fatal_err == 1, "R7 fatal raised", fatal_err, 1);
    bank_fault = 2'b00;
    fetch1(0, 31, lat, d, bk, r2);
    chk(lat == 3 && d == mword(31), "R2 after fatal", d, mword(31));
    chk(fatal_err == 1, "R7 fatal sticky", fatal_err, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule